// File: doc/BRIEF.md
# Line Read Buffer with Sequential Prefetch

This block sits between the read side of one or more bus masters and an SDRAM controller. It keeps a small number of cache lines (four doublewords each by default) and answers master reads from them. A read whose doubleword is not held makes the buffer request a line fill from the memory side. Returned doublewords are written into a line entry one at a time. The waiting master is answered as soon as its own doubleword arrives.

A read-ahead enable decides whether burst reads also pull in the next sequential line. A burst read that misses fetches the whole current line. When read-ahead is on, it then fetches the following line as well, unless that line is already buffered. A single-doubleword read fetches only the part of its line from the requested doubleword to the end, and it never starts a prefetch. A write-snoop input removes any buffered line that a write touches, so later reads see fresh memory data.

Masters hold a request until it is acknowledged. The memory side grants a fill request and then returns doublewords in ascending order from the requested start offset to the end of the line.

Top module: `rdbuf_prefetch`

## Requirements
- R1: After reset no fill request is raised, no read is acknowledged, and read-ahead is off.
- R2: A read whose doubleword is buffered is acknowledged in the same cycle it is presented, and no fill request follows it.
- R3: A burst read miss issues a fill request whose line number is the read address shifted right by two bits (address bits [1:0] select the doubleword in the line), with start offset 0.
- R4: A single (non-burst) read miss issues a fill with start offset equal to address bits [1:0]. Doublewords of that line below the offset stay absent, so a later read of one of them misses again.
- R5: With read-ahead on, a burst read miss is followed by a second fill request for line number plus one, at start offset 0.
- R6: With read-ahead on, a single read miss produces exactly one fill request.
- R7: With read-ahead off, a burst read miss produces exactly one fill request.
- R8: The next-line request is suppressed when any doubleword of that next line is already buffered.
- R9: A snoop write whose address falls in a buffered line removes that whole line. A snoop to a line that is not buffered changes nothing.
- R10: A snoop write to the line being filled, at any time during the fill, makes the rest of that fill unusable. The pending read is then re-fetched and returns post-write data.
- R11: Every acknowledged read returns the memory content of its address as of the acknowledge cycle.
- R12: A fill request holds its line and start offset stable until it is granted.
- R13: Two line entries are replaced in round-robin order. A buffered line occupies at most one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ra_en | input | 1 | Read-ahead enable, registered inside |
| rd_req | input | 1 | Master read request, held until rd_ack |
| rd_addr | input | AW | Doubleword address of the read |
| rd_burst | input | 1 | Request is part of a burst of two or more doublewords |
| rd_ack | output | 1 | Read answered this cycle |
| rd_data | output | DW | Read data, valid with rd_ack |
| mem_req | output | 1 | Fill request to the memory side |
| mem_line | output | AW-2 | Line number to fill |
| mem_offs | output | 2 | First doubleword of the fill |
| mem_gnt | input | 1 | Fill request accepted |
| mem_dvalid | input | 1 | A fill doubleword is on mem_data |
| mem_data | input | DW | Fill data |
| snp_we | input | 1 | A write to memory is seen |
| snp_addr | input | AW | Doubleword address of the snooped write |

## Verification
Reads are tried as bursts and as single doublewords, with read-ahead on and off. The fill requests these reads produce show whether prefetch is tied to the burst flag and to the enable, and whether the start offset follows the burst type. A burst miss whose next line is partly buffered tells a working suppression check from a blind prefetch. Snoops are placed on a buffered line, on an unrelated line, and in the middle of an outstanding fill. Fresh and stale data differ in every case, so a missed invalidation or an accepted poisoned fill shows up as a data mismatch. Three new lines read in a row show the replacement order.

// File: rtl/rdbuf_pkg.sv
package rdbuf_pkg;
  typedef enum logic [2:0] {
    RB_IDLE  = 3'd0,
    RB_DREQ  = 3'd1,
    RB_DFILL = 3'd2,
    RB_PREQ  = 3'd3,
    RB_PFILL = 3'd4
  } rb_state_e;

  // round-robin step over n entries
  function automatic int unsigned rr_next(input int unsigned idx, input int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/rdbuf_store.sv
module rdbuf_store #(
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int LINE_DW = 4,
  parameter int NENT    = 2,
  localparam int OFFS_W = $clog2(LINE_DW),
  localparam int LINE_W = AW - OFFS_W,
  localparam int EIDX_W = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  // master lookup
  input  logic [LINE_W-1:0] lk_line,
  input  logic [OFFS_W-1:0] lk_offs,
  output logic              lk_hit,
  output logic [DW-1:0]     lk_data,
  output logic              lk_own,
  output logic [EIDX_W-1:0] lk_own_idx,
  // next-line presence
  input  logic [LINE_W-1:0] pf_line,
  output logic              pf_present,
  // entry allocation
  input  logic              alloc_en,
  input  logic [EIDX_W-1:0] alloc_idx,
  input  logic [LINE_W-1:0] alloc_line,
  input  logic              alloc_keep,
  // fill write
  input  logic              wr_en,
  input  logic [EIDX_W-1:0] wr_idx,
  input  logic [OFFS_W-1:0] wr_offs,
  input  logic [DW-1:0]     wr_data,
  // snoop invalidation
  input  logic              snp_en,
  input  logic [LINE_W-1:0] snp_line
);
  logic [LINE_W-1:0]  tag_q [NENT];
  logic [LINE_DW-1:0] vld_q [NENT];
  logic [DW-1:0]      dat_q [NENT][LINE_DW];
  logic [NENT-1:0]    own_vec;
  logic [NENT-1:0]    hit_vec;
  logic [NENT-1:0]    pf_vec;

  for (genvar j = 0; j < NENT; j++) begin : g_ent
    logic [LINE_W-1:0]  tag_n;
    logic [LINE_DW-1:0] vld_n;
    logic               alloc_me;
    logic               wr_me;

    assign alloc_me = alloc_en && (alloc_idx == EIDX_W'(j));
    assign wr_me    = wr_en && (wr_idx == EIDX_W'(j));

    always_comb begin
      tag_n = tag_q[j];
      vld_n = vld_q[j];
      if (alloc_me) begin
        tag_n = alloc_line;
        if (!alloc_keep) vld_n = '0;
      end
      if (wr_me) vld_n[wr_offs] = 1'b1;
      // a snooped write wins over a fill beat in the same cycle
      if (snp_en && (tag_n == snp_line)) vld_n = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q[j] <= '0;
        vld_q[j] <= '0;
      end else begin
        tag_q[j] <= tag_n;
        vld_q[j] <= vld_n;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_me) dat_q[j][wr_offs] <= wr_data;
    end

    assign own_vec[j] = (tag_q[j] == lk_line) && (|vld_q[j]);
    assign hit_vec[j] = (tag_q[j] == lk_line) && vld_q[j][lk_offs];
    assign pf_vec[j]  = (tag_q[j] == pf_line) && (|vld_q[j]);

    // R9: a matching snoop leaves the entry empty on the next cycle
    p_snoop_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_en && (tag_q[j] == snp_line)) |=> (vld_q[j] == '0));
  end

  always_comb begin
    lk_data    = '0;
    lk_own_idx = '0;
    for (int j = 0; j < NENT; j++) begin
      if (hit_vec[j]) lk_data = dat_q[j][lk_offs];
      if (own_vec[j]) lk_own_idx = EIDX_W'(j);
    end
  end

  assign lk_hit     = |hit_vec;
  assign lk_own     = |own_vec;
  assign pf_present = |pf_vec;

  // R13: one line never sits in two entries
  p_unique_line_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(own_vec));
endmodule

// File: rtl/rdbuf_ctrl.sv
module rdbuf_ctrl
  import rdbuf_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int LINE_DW = 4,
  parameter int NENT    = 2,
  localparam int OFFS_W = $clog2(LINE_DW),
  localparam int LINE_W = AW - OFFS_W,
  localparam int EIDX_W = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ra_en,
  input  logic              rd_req,
  input  logic [AW-1:0]     rd_addr,
  input  logic              rd_burst,
  output logic              rd_ack,
  input  logic              snp_we,
  input  logic [AW-1:0]     snp_addr,
  output logic              mem_req,
  output logic [LINE_W-1:0] mem_line,
  output logic [OFFS_W-1:0] mem_offs,
  input  logic              mem_gnt,
  input  logic              mem_dvalid,
  // store side
  output logic [LINE_W-1:0] lk_line,
  output logic [OFFS_W-1:0] lk_offs,
  input  logic              lk_hit,
  input  logic              lk_own,
  input  logic [EIDX_W-1:0] lk_own_idx,
  output logic [LINE_W-1:0] pf_line,
  input  logic              pf_present,
  output logic              alloc_en,
  output logic [EIDX_W-1:0] alloc_idx,
  output logic [LINE_W-1:0] alloc_line,
  output logic              alloc_keep,
  output logic              wr_en,
  output logic [EIDX_W-1:0] wr_idx,
  output logic [OFFS_W-1:0] wr_offs,
  output logic              snp_en,
  output logic [LINE_W-1:0] snp_line
);
  function automatic logic [LINE_W-1:0] line_of(input logic [AW-1:0] a);
    return a[AW-1:OFFS_W];
  endfunction

  function automatic logic [OFFS_W-1:0] offs_of(input logic [AW-1:0] a);
    return a[OFFS_W-1:0];
  endfunction

  function automatic logic [EIDX_W-1:0] step(input logic [EIDX_W-1:0] i);
    return EIDX_W'(rr_next(int'(i), NENT));
  endfunction

  rb_state_e         st_q;
  logic              ra_q;
  logic              pf_arm_q;
  logic              drop_q;
  logic [EIDX_W-1:0] fill_idx_q;
  logic [EIDX_W-1:0] vic_q;
  logic [LINE_W-1:0] fill_line_q;
  logic [OFFS_W-1:0] cnt_q;

  // named internal events
  logic              in_fill;
  logic              miss_go;
  logic              last_beat;
  logic              pf_go;
  logic              snp_hits_fill;
  logic [EIDX_W-1:0] vic_alt;

  assign lk_line  = line_of(rd_addr);
  assign lk_offs  = offs_of(rd_addr);
  assign snp_en   = snp_we;
  assign snp_line = line_of(snp_addr);
  assign pf_line  = LINE_W'(fill_line_q + 1'b1);

  assign in_fill       = (st_q == RB_DFILL) || (st_q == RB_PFILL);
  assign miss_go       = (st_q == RB_IDLE) && rd_req && !lk_hit;
  assign last_beat     = in_fill && mem_dvalid && (cnt_q == OFFS_W'(LINE_DW - 1));
  assign pf_go         = (st_q == RB_DFILL) && last_beat && pf_arm_q && !pf_present;
  assign snp_hits_fill = snp_we && (snp_line == fill_line_q);
  assign vic_alt       = (vic_q == fill_idx_q) ? step(vic_q) : vic_q;

  assign rd_ack   = rd_req && lk_hit;
  assign mem_req  = (st_q == RB_DREQ) || (st_q == RB_PREQ);
  assign mem_line = fill_line_q;
  assign mem_offs = cnt_q;

  assign wr_en   = in_fill && mem_dvalid && !drop_q;
  assign wr_idx  = fill_idx_q;
  assign wr_offs = cnt_q;

  always_comb begin
    alloc_en   = 1'b0;
    alloc_idx  = vic_q;
    alloc_line = lk_line;
    alloc_keep = 1'b0;
    if (miss_go) begin
      alloc_en   = 1'b1;
      alloc_idx  = lk_own ? lk_own_idx : vic_q;
      alloc_keep = lk_own;
    end else if (pf_go) begin
      alloc_en   = 1'b1;
      alloc_idx  = vic_alt;
      alloc_line = pf_line;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= RB_IDLE;
      ra_q        <= 1'b0;
      pf_arm_q    <= 1'b0;
      drop_q      <= 1'b0;
      fill_idx_q  <= '0;
      vic_q       <= '0;
      fill_line_q <= '0;
      cnt_q       <= '0;
    end else begin
      ra_q <= ra_en;
      unique case (st_q)
        RB_IDLE: begin
          if (miss_go) begin
            st_q        <= RB_DREQ;
            fill_idx_q  <= alloc_idx;
            fill_line_q <= lk_line;
            cnt_q       <= rd_burst ? '0 : lk_offs;
            pf_arm_q    <= ra_q && rd_burst;
            drop_q      <= snp_we && (snp_line == lk_line);
            if (!lk_own) vic_q <= step(vic_q);
          end
        end
        RB_DREQ, RB_PREQ: begin
          if (snp_hits_fill) drop_q <= 1'b1;
          if (mem_gnt) st_q <= (st_q == RB_DREQ) ? RB_DFILL : RB_PFILL;
        end
        RB_DFILL, RB_PFILL: begin
          if (snp_hits_fill) drop_q <= 1'b1;
          if (mem_dvalid) cnt_q <= cnt_q + 1'b1;
          if (last_beat) begin
            if (pf_go) begin
              st_q        <= RB_PREQ;
              fill_idx_q  <= vic_alt;
              fill_line_q <= pf_line;
              cnt_q       <= '0;
              drop_q      <= snp_we && (snp_line == pf_line);
              vic_q       <= step(vic_alt);
            end else begin
              st_q <= RB_IDLE;
            end
          end
        end
        default: st_q <= RB_IDLE;
      endcase
    end
  end

  // R12: an ungranted request keeps its line and offset
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_line) && $stable(mem_offs)));

  // R2: a hit taken while idle starts no fill
  p_hit_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == RB_IDLE) && rd_req && lk_hit) |=> !mem_req);

  // R5: the prefetch asks for the line right after the demand line
  p_pf_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == RB_PREQ) && ($past(st_q) == RB_DFILL)) |->
      (mem_line == LINE_W'($past(mem_line) + 1'b1)) && (mem_offs == '0));

  // R6: a prefetch phase only exists behind an armed burst miss
  p_pf_armed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RB_PREQ) |-> pf_arm_q);
endmodule

// File: rtl/rdbuf_prefetch.sv
module rdbuf_prefetch #(
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int LINE_DW = 4,
  parameter int NENT    = 2,
  localparam int OFFS_W = $clog2(LINE_DW),
  localparam int LINE_W = AW - OFFS_W,
  localparam int EIDX_W = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ra_en,
  input  logic              rd_req,
  input  logic [AW-1:0]     rd_addr,
  input  logic              rd_burst,
  output logic              rd_ack,
  output logic [DW-1:0]     rd_data,
  output logic              mem_req,
  output logic [LINE_W-1:0] mem_line,
  output logic [OFFS_W-1:0] mem_offs,
  input  logic              mem_gnt,
  input  logic              mem_dvalid,
  input  logic [DW-1:0]     mem_data,
  input  logic              snp_we,
  input  logic [AW-1:0]     snp_addr
);
  logic [LINE_W-1:0] lk_line;
  logic [OFFS_W-1:0] lk_offs;
  logic              lk_hit;
  logic              lk_own;
  logic [EIDX_W-1:0] lk_own_idx;
  logic [LINE_W-1:0] pf_line;
  logic              pf_present;
  logic              alloc_en;
  logic [EIDX_W-1:0] alloc_idx;
  logic [LINE_W-1:0] alloc_line;
  logic              alloc_keep;
  logic              wr_en;
  logic [EIDX_W-1:0] wr_idx;
  logic [OFFS_W-1:0] wr_offs;
  logic              snp_en;
  logic [LINE_W-1:0] snp_line;

  rdbuf_ctrl #(.AW(AW), .DW(DW), .LINE_DW(LINE_DW), .NENT(NENT)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ra_en      (ra_en),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .rd_burst   (rd_burst),
    .rd_ack     (rd_ack),
    .snp_we     (snp_we),
    .snp_addr   (snp_addr),
    .mem_req    (mem_req),
    .mem_line   (mem_line),
    .mem_offs   (mem_offs),
    .mem_gnt    (mem_gnt),
    .mem_dvalid (mem_dvalid),
    .lk_line    (lk_line),
    .lk_offs    (lk_offs),
    .lk_hit     (lk_hit),
    .lk_own     (lk_own),
    .lk_own_idx (lk_own_idx),
    .pf_line    (pf_line),
    .pf_present (pf_present),
    .alloc_en   (alloc_en),
    .alloc_idx  (alloc_idx),
    .alloc_line (alloc_line),
    .alloc_keep (alloc_keep),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_offs    (wr_offs),
    .snp_en     (snp_en),
    .snp_line   (snp_line)
  );

  rdbuf_store #(.AW(AW), .DW(DW), .LINE_DW(LINE_DW), .NENT(NENT)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_line    (lk_line),
    .lk_offs    (lk_offs),
    .lk_hit     (lk_hit),
    .lk_data    (rd_data),
    .lk_own     (lk_own),
    .lk_own_idx (lk_own_idx),
    .pf_line    (pf_line),
    .pf_present (pf_present),
    .alloc_en   (alloc_en),
    .alloc_idx  (alloc_idx),
    .alloc_line (alloc_line),
    .alloc_keep (alloc_keep),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_offs    (wr_offs),
    .wr_data    (mem_data),
    .snp_en     (snp_en),
    .snp_line   (snp_line)
  );
endmodule

// File: tb/rdbuf_prefetch_tb_top.sv
module rdbuf_prefetch_tb_top;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int LDW = 4;
  localparam int LW = AW - 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ra_en = 1'b0;
  logic          rd_req = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          rd_burst = 1'b0;
  logic          rd_ack;
  logic [DW-1:0] rd_data;
  logic          mem_req;
  logic [LW-1:0] mem_line;
  logic [1:0]    mem_offs;
  logic          mem_gnt = 1'b0;
  logic          mem_dvalid = 1'b0;
  logic [DW-1:0] mem_data = '0;
  logic          snp_we = 1'b0;
  logic [AW-1:0] snp_addr = '0;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  int ver[int];
  int fl_line[$];
  int fl_offs[$];

  always #5 clk = ~clk;

  rdbuf_prefetch dut_i (
    .clk(clk), .rst_n(rst_n), .ra_en(ra_en),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_burst(rd_burst),
    .rd_ack(rd_ack), .rd_data(rd_data),
    .mem_req(mem_req), .mem_line(mem_line), .mem_offs(mem_offs),
    .mem_gnt(mem_gnt), .mem_dvalid(mem_dvalid), .mem_data(mem_data),
    .snp_we(snp_we), .snp_addr(snp_addr)
  );

  function automatic int ver_of(input int line);
    return ver.exists(line) ? ver[line] : 0;
  endfunction

  // memory model: content depends on address and on how often its line was written
  function automatic logic [31:0] word(input int a);
    return (32'(a) * 32'h9E3779B1) ^ (32'(ver_of(a / LDW)) * 32'h01000193);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // writes seen on the snoop port update the memory model at the edge
  always @(posedge clk) begin
    if (snp_we) ver[int'(snp_addr) / LDW] = ver_of(int'(snp_addr) / LDW) + 1;
  end

  // R12 watched on every clock: an ungranted request must not move
  logic          pend_q = 1'b0;
  logic [LW-1:0] pend_line;
  logic [1:0]    pend_offs;
  always @(negedge clk) begin
    if (rst_n && pend_q) begin
      check(mem_req && mem_line == pend_line && mem_offs == pend_offs, "R12",
            {mem_req, mem_line, mem_offs}, {1'b1, pend_line, pend_offs});
    end
  end
  always @(posedge clk) begin
    pend_q    <= mem_req && !mem_gnt && rst_n;
    pend_line <= mem_line;
    pend_offs <= mem_offs;
  end

  // memory side: grant, one idle cycle, then ascending doublewords
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_req) begin
        automatic int l = int'(mem_line);
        automatic int o = int'(mem_offs);
        fl_line.push_back(l);
        fl_offs.push_back(o);
        mem_gnt = 1'b1;
        @(negedge clk);
        mem_gnt = 1'b0;
        @(negedge clk);
        for (int k = o; k < LDW; k++) begin
          mem_dvalid = 1'b1;
          mem_data   = word(l * LDW + k);
          @(negedge clk);
        end
        mem_dvalid = 1'b0;
      end
    end
  end

  // one read; lat counts cycles waited before the acknowledge; R11 checked here
  task automatic rd(input int a, input bit b, output int lat);
    @(negedge clk);
    rd_req = 1'b1; rd_addr = AW'(a); rd_burst = b; lat = 0;
    #1;
    while (!rd_ack && lat < 400) begin
      @(negedge clk); #1; lat++;
    end
    check(rd_ack === 1'b1, "R11 ack", rd_ack, 1);
    check(rd_data == word(a), "R11 data", rd_data, word(a));
    @(negedge clk);
    rd_req = 1'b0; rd_burst = 1'b0;
  endtask

  task automatic snoop(input int a);
    @(negedge clk);
    snp_we = 1'b1; snp_addr = AW'(a);
    @(negedge clk);
    snp_we = 1'b0;
  endtask

  task automatic settle();
    repeat (16) @(negedge clk);
  endtask

  task automatic clear_log();
    fl_line.delete();
    fl_offs.delete();
  endtask

  task automatic expect_fill(input int i, input int line, input int offs, input string req);
    if (i < fl_line.size()) begin
      check(fl_line[i] == line && fl_offs[i] == offs, req,
            fl_line[i] * 16 + fl_offs[i], line * 16 + offs);
    end else begin
      check(1'b0, req, -1, line * 16 + offs);
    end
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R1: quiet outputs in and after reset
    check(mem_req == 1'b0 && rd_ack == 1'b0, "R1 reset", {mem_req, rd_ack}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(mem_req == 1'b0 && rd_ack == 1'b0, "R1 idle", {mem_req, rd_ack}, 0);

    // R3 / R7 / R1: burst miss, read-ahead left at its reset value
    clear_log();
    rd(16'h0105, 1'b1, lat);
    settle();
    check(fl_line.size() == 1, "R7 one fill", fl_line.size(), 1);
    expect_fill(0, 16'h0105 >> 2, 0, "R3 line and offset");
    rd(16'h0104, 1'b0, lat);
    check(lat == 0, "R2 hit latency", lat, 0);
    rd(16'h0107, 1'b1, lat);
    check(lat == 0, "R2 hit latency", lat, 0);
    settle();
    check(fl_line.size() == 1, "R2 no fill on hit", fl_line.size(), 1);

    // R4: single read fetches only the remainder
    clear_log();
    rd(16'h0202, 1'b0, lat);
    settle();
    expect_fill(0, 16'h0202 >> 2, 2, "R4 remainder offset");
    rd(16'h0203, 1'b0, lat);
    check(lat == 0, "R4 upper dword held", lat, 0);
    rd(16'h0200, 1'b0, lat);
    settle();
    check(lat > 0, "R4 lower dword absent", lat, 1);
    expect_fill(1, 16'h0200 >> 2, 0, "R4 refill of lower part");

    // R5: read-ahead on, burst miss pulls the next line
    ra_en = 1'b1;
    repeat (2) @(negedge clk);
    clear_log();
    rd(16'h0300, 1'b1, lat);
    settle();
    check(fl_line.size() == 2, "R5 two fills", fl_line.size(), 2);
    expect_fill(0, 16'h0300 >> 2, 0, "R5 demand fill");
    expect_fill(1, (16'h0300 >> 2) + 1, 0, "R5 next line fill");
    rd(16'h0305, 1'b1, lat);
    check(lat == 0, "R5 prefetched hit", lat, 0);

    // R6: read-ahead on, single miss stays at one fill
    clear_log();
    rd(16'h0402, 1'b0, lat);
    settle();
    check(fl_line.size() == 1, "R6 single fill", fl_line.size(), 1);
    expect_fill(0, 16'h0402 >> 2, 2, "R6 remainder offset");

    // R8: next line partly buffered, so no prefetch
    clear_log();
    rd(16'h03FC, 1'b1, lat);
    settle();
    check(fl_line.size() == 1, "R8 suppressed", fl_line.size(), 1);
    rd(16'h0402, 1'b0, lat);
    check(lat == 0, "R8 next line kept", lat, 0);

    // R9: snoop on a buffered line, then on an unrelated one
    ra_en = 1'b0;
    repeat (2) @(negedge clk);
    rd(16'h0403, 1'b0, lat);
    check(lat == 0, "R9 before snoop", lat, 0);
    clear_log();
    snoop(16'h0401);
    rd(16'h0403, 1'b0, lat);
    settle();
    check(lat > 0, "R9 line removed", lat, 1);
    expect_fill(0, 16'h0403 >> 2, 3, "R9 refetch");
    snoop(16'h0999);
    rd(16'h0403, 1'b0, lat);
    check(lat == 0, "R9 unrelated snoop", lat, 0);

    // R10: snoop while the fill is outstanding
    clear_log();
    fork
      rd(16'h0500, 1'b0, lat);
      begin
        wait (mem_gnt == 1'b1);
        @(negedge clk);
        snp_we = 1'b1; snp_addr = 16'h0501;
        @(negedge clk);
        snp_we = 1'b0;
      end
    join
    settle();
    check(fl_line.size() == 2, "R10 refetch count", fl_line.size(), 2);
    expect_fill(1, 16'h0500 >> 2, 0, "R10 second fill");

    // R13: three new lines, the oldest is the one replaced
    rd(16'h0600, 1'b0, lat);
    rd(16'h0610, 1'b0, lat);
    rd(16'h0620, 1'b0, lat);
    settle();
    rd(16'h0611, 1'b0, lat);
    check(lat == 0, "R13 second line kept", lat, 0);
    clear_log();
    rd(16'h0601, 1'b0, lat);
    settle();
    check(lat > 0 && fl_line.size() == 1, "R13 oldest line replaced", lat, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule